// File: doc/BRIEF.md
# Byte Shift-Rotate-Complement Unit

This unit performs the single-operand transformations of a read-modify-write step: shifts, rotates (through carry and within the byte), increment, decrement and bitwise complement. It accepts an 8-bit operand, a 4-bit function code and the current N, Z and C flags. It returns the transformed byte and the new N, Z and C values. The same path serves an accumulator operand and a memory byte. The overflow flag is not an input or an output, so the unit never alters it.

Requests come in on a valid/ready stream, and results leave on a second valid/ready stream one clock after acceptance. A single output register sits between them. A request is taken when the register is empty or is being drained in the same cycle. Back-pressure works as follows: while `out_valid` is high and `out_ready` is low, the result is held unchanged and `in_ready` is low. When `out_ready` is high, a new request can replace the departing result in the same cycle, so full throughput is kept.

Top module: `byte_rmw_unit`

## Requirements
- R1: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. A request is accepted on a clock edge where `in_valid` and `in_ready` are both high, and `out_valid` is high in the following cycle.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and the flags hold. When the result is drained with no new request accepted, `out_valid` falls in the next cycle.
- R3: Code 0 shifts left with a zero fill, and C takes old bit 7. Code 1 shifts right with a zero fill, C takes old bit 0, and N is therefore 0.
- R4: Code 2 rotates left through carry: the incoming C fills bit 0 and old bit 7 goes to C. Code 3 rotates right through carry: the incoming C fills bit 7 and old bit 0 goes to C.
- R5: Code 4 adds one and code 5 subtracts one, both modulo 256. C is returned unchanged.
- R6: Code 6 shifts right arithmetically: bit 7 is kept, the other bits move right by one, and old bit 0 goes to C.
- R7: Code 7 rotates left within the byte, so old bit 7 goes to both bit 0 and C. Code 8 rotates right within the byte, so old bit 0 goes to both bit 7 and C.
- R8: Code 9 inverts all eight bits and returns C unchanged.
- R9: For codes 0 to 9, N equals result bit 7 and Z is high exactly when the result is zero.
- R10: Codes 10 to 15 return the operand and the incoming N, Z and C unchanged.
- R11: While `rst_n` is low, and after its release until the first accepted request, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_func | input | 4 | Function code (see R3 to R10) |
| in_data | input | 8 | Operand byte |
| in_n | input | 1 | Incoming negative flag |
| in_z | input | 1 | Incoming zero flag |
| in_c | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 8 | Result byte |
| out_n | output | 1 | New negative flag |
| out_z | output | 1 | New zero flag |
| out_c | output | 1 | New carry flag |

## Verification
The two events that can share a cycle are draining the held result and accepting a new request into the same register. The bench keeps `in_valid` high for long runs while `out_ready` switches between always high, random and mostly low, so refill-on-drain, stalls and drain-only cycles all occur. A behavioural model predicts `in_ready`, `out_valid` and the held result on every clock. A lost, duplicated or overwritten result therefore shows up as a miscompare at the cycle where it happens. Operands are biased towards 0x00, 0x01, 0x7F, 0x80 and 0xFF, with both carry values, so that every fill and carry edge is reached.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  localparam int DATA_W = 8;
  localparam int FUNC_W = 4;

  typedef enum logic [FUNC_W-1:0] {
    FN_SHL    = 4'd0,
    FN_SHR    = 4'd1,
    FN_ROLC   = 4'd2,
    FN_RORC   = 4'd3,
    FN_INC    = 4'd4,
    FN_DEC    = 4'd5,
    FN_SAR    = 4'd6,
    FN_ROL8   = 4'd7,
    FN_ROR8   = 4'd8,
    FN_INV    = 4'd9
  } rmw_fn_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              n;
    logic              z;
    logic              c;
  } rmw_res_t;
endpackage

// File: rtl/rmw_datapath.sv
module rmw_datapath
  import rmw_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int FW = FUNC_W
) (
  input  logic [FW-1:0] func,
  input  logic [W-1:0]  opnd,
  input  logic          c_in,
  output logic [W-1:0]  res,
  output logic          c_out,
  output logic          known
);
  localparam int MSB = W - 1;

  always_comb begin
    res   = opnd;
    c_out = c_in;
    known = 1'b1;
    case (func)
      FN_SHL:  begin res = {opnd[MSB-1:0], 1'b0};       c_out = opnd[MSB]; end
      FN_SHR:  begin res = {1'b0, opnd[MSB:1]};         c_out = opnd[0];   end
      FN_ROLC: begin res = {opnd[MSB-1:0], c_in};       c_out = opnd[MSB]; end
      FN_RORC: begin res = {c_in, opnd[MSB:1]};         c_out = opnd[0];   end
      FN_INC:  res = opnd + W'(1);
      FN_DEC:  res = opnd - W'(1);
      FN_SAR:  begin res = {opnd[MSB], opnd[MSB:1]};    c_out = opnd[0];   end
      FN_ROL8: begin res = {opnd[MSB-1:0], opnd[MSB]};  c_out = opnd[MSB]; end
      FN_ROR8: begin res = {opnd[0], opnd[MSB:1]};      c_out = opnd[0];   end
      FN_INV:  res = ~opnd;
      default: known = 1'b0;
    endcase
  end

  always_comb begin
    if (func == FN_SAR)
      assert_sar_keeps_sign_R6: assert (res[MSB] == opnd[MSB]);
    if (func == FN_INC || func == FN_DEC || func == FN_INV)
      assert_carry_untouched_R5: assert (c_out == c_in);
    if (func == FN_SHR)
      assert_shr_top_clear_R3: assert (res[MSB] == 1'b0);
  end
endmodule

// File: rtl/rmw_flag_gen.sv
module rmw_flag_gen #(
  parameter int W = rmw_pkg::DATA_W
) (
  input  logic [W-1:0] res,
  input  logic         known,
  input  logic         n_in,
  input  logic         z_in,
  output logic         n_out,
  output logic         z_out
);
  always_comb begin
    if (known) begin
      n_out = res[W-1];
      z_out = (res == '0);
    end else begin
      n_out = n_in;
      z_out = z_in;
    end
  end
endmodule

// File: rtl/rmw_out_stage.sv
module rmw_out_stage
  import rmw_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     take,
  input  rmw_res_t nxt,
  input  logic     drain,
  output logic     full,
  output rmw_res_t held
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      held <= '0;
    end else if (take) begin
      full <= 1'b1;
      held <= nxt;
    end else if (drain) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/byte_rmw_unit.sv
module byte_rmw_unit
  import rmw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [FUNC_W-1:0] in_func,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_n,
  input  logic              in_z,
  input  logic              in_c,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_n,
  output logic              out_z,
  output logic              out_c
);
  logic [DATA_W-1:0] dp_res;
  logic              dp_c, dp_known, fg_n, fg_z, accept;
  rmw_res_t          nxt, held;

  rmw_datapath #(.W(DATA_W), .FW(FUNC_W)) u_dp (
    .func(in_func), .opnd(in_data), .c_in(in_c),
    .res(dp_res), .c_out(dp_c), .known(dp_known)
  );

  rmw_flag_gen #(.W(DATA_W)) u_fg (
    .res(dp_res), .known(dp_known), .n_in(in_n), .z_in(in_z),
    .n_out(fg_n), .z_out(fg_z)
  );

  assign nxt      = '{data: dp_res, n: fg_n, z: fg_z, c: dp_c};
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  rmw_out_stage u_os (
    .clk(clk), .rst_n(rst_n), .take(accept), .nxt(nxt),
    .drain(out_ready), .full(out_valid), .held(held)
  );

  assign out_data = held.data;
  assign out_n    = held.n;
  assign out_z    = held.z;
  assign out_c    = held.c;

  assert_valid_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  assert_stall_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_c)
                                   && $stable(out_n) && $stable(out_z)));

  assert_drain_empties_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  assert_stall_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/sim_byte_rmw_unit.sv
module sim_byte_rmw_unit;
  localparam int CLK_P = 10;
  localparam int N_CYC = 6000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [3:0] in_func = '0;
  logic [7:0] in_data = '0;
  logic in_n = 1'b0, in_z = 1'b0, in_c = 1'b0;
  logic in_ready, out_valid, out_n, out_z, out_c;
  logic [7:0] out_data;

  int vecs = 0, errs = 0;
  bit m_valid = 1'b0;
  int m_data = 0, m_func = 0;
  bit m_n = 1'b0, m_z = 1'b0, m_c = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  byte_rmw_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_func(in_func), .in_data(in_data), .in_n(in_n), .in_z(in_z), .in_c(in_c),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_n(out_n), .out_z(out_z), .out_c(out_c)
  );

  function automatic string tag_of(int f);
    case (f)
      0, 1: return "R3";
      2, 3: return "R4";
      4, 5: return "R5";
      6:    return "R6";
      7, 8: return "R7";
      9:    return "R8";
      default: return "R10";
    endcase
  endfunction

  // Behavioural model: returns result byte, sets flags by reference
  function automatic int ref_calc(int f, int d, bit ni, bit zi, bit ci,
                                  output bit no, output bit zo, output bit co);
    int r;
    co = ci;
    case (f)
      0: begin r = (d * 2) % 256;           co = (d >= 128); end
      1: begin r = d / 2;                   co = (d % 2 == 1); end
      2: begin r = (d * 2) % 256 + int'(ci); co = (d >= 128); end
      3: begin r = d / 2 + 128 * int'(ci);  co = (d % 2 == 1); end
      4: r = (d + 1) % 256;
      5: r = (d + 255) % 256;
      6: begin r = d / 2 + (d >= 128 ? 128 : 0); co = (d % 2 == 1); end
      7: begin r = (d * 2) % 256 + (d >= 128 ? 1 : 0); co = (d >= 128); end
      8: begin r = d / 2 + (d % 2) * 128;   co = (d % 2 == 1); end
      9: r = 255 - d;
      default: r = d;
    endcase
    if (f <= 9) begin
      no = (r >= 128);
      zo = (r == 0);
    end else begin
      no = ni;
      zo = zi;
    end
    return r;
  endfunction

  function automatic bit mdl_ready();
    return !m_valid || out_ready;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) m_valid <= 1'b0;
    else if (in_valid && mdl_ready()) begin
      bit a, b, c;
      int r;
      r = ref_calc(int'(in_func), int'(in_data), in_n, in_z, in_c, a, b, c);
      m_valid <= 1'b1;
      m_data <= r; m_n <= a; m_z <= b; m_c <= c; m_func <= int'(in_func);
    end else if (out_ready) m_valid <= 1'b0;
  end

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(out_valid == m_valid, (rst_n ? "R2" : "R11"), "out_valid", int'(out_valid), int'(m_valid));
    chk(in_ready == mdl_ready(), "R1", "in_ready", int'(in_ready), int'(mdl_ready()));
    if (m_valid && out_valid) begin
      chk(int'(out_data) == m_data, tag_of(m_func), "data", int'(out_data), m_data);
      chk(out_c == m_c, tag_of(m_func), "carry", int'(out_c), int'(m_c));
      chk(out_n == m_n, (m_func <= 9 ? "R9" : "R10"), "N", int'(out_n), int'(m_n));
      chk(out_z == m_z, (m_func <= 9 ? "R9" : "R10"), "Z", int'(out_z), int'(m_z));
    end
  endtask

  function automatic logic [7:0] pick_data();
    case ($urandom_range(0, 7))
      0: return 8'h00;
      1: return 8'h01;
      2: return 8'h7F;
      3: return 8'h80;
      4: return 8'hFF;
      default: return 8'($urandom);
    endcase
  endfunction

  bit done = 1'b0;

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    // reset state (R11)
    repeat (3) begin
      @(negedge clk);
      compare();
    end
    rst_n = 1'b1;
    for (int i = 0; i < N_CYC; i++) begin
      @(negedge clk);
      compare();
      case (i / 1000)
        0: out_ready = 1'b1;
        1: out_ready = ($urandom_range(0, 1) == 1);
        2: out_ready = ($urandom_range(0, 4) == 0);
        3: out_ready = 1'b1;
        default: out_ready = ($urandom_range(0, 2) != 0);
      endcase
      in_valid = (i / 1000 == 3) ? 1'b1 : ($urandom_range(0, 3) != 0);
      in_func  = 4'($urandom_range(0, 15));
      in_data  = pick_data();
      in_n     = 1'($urandom);
      in_z     = 1'($urandom);
      in_c     = 1'($urandom);
    end
    @(negedge clk);
    compare();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule